// File: doc/BRIEF.md
# Timer Channel: Capture, Compare and PWM

This block is one channel of a general-purpose timer. It watches a shared free-running up-counter that wraps at a modulo value set elsewhere, together with the one-cycle strobe that marks each wrap. Depending on a two-bit mode field and a two-bit edge/level field, the channel does one of four jobs. It can preload an output level while the pin stays with the port logic. It can latch the counter value on chosen edges of an input pin. It can act on its output pin when the counter equals a compare value, with that value written directly. Or it can do the same with the compare value staged in a shadow register and applied only at the wrap.

For pulse-width modulation, a toggle-on-overflow input makes the pin act at every wrap and the compare clears it again, so the compare value sets the duty. A maximum-duty input forces a full-high period. It is sampled only at a wrap, so a change never cuts into a period that has already started. A sticky event flag records every compare match in an output mode and every qualifying capture edge. Software clears the flag by writing a one to it.

The register write port is a single-cycle strobe (`wr_valid`). It has no ready signal because the channel takes a write in every cycle, so no back-pressure exists. All other pins are plain levels.

Top module: `timer_chan`

## Requirements
- R1: After reset the mode and edge/level fields, the compare value, the captured value, the event flag and the output level are all zero. `pin_en` is low.
- R2: Writing the control word (`wr_sel`=0, `wr_data[3:2]`=mode, `wr_data[1:0]`=edge/level) with edge/level 00 releases the pin: `pin_en` goes low. From the next cycle the output level is 1 if mode bit 0 (`wr_data[2]`) is 0, and 0 if it is 1.
- R3: In mode 00 the channel captures on the input pin. Edge/level 01 selects rising edges, 10 falling edges and 11 both. In the cycle after a qualifying edge, `cap_val` holds the counter value from the edge cycle and the flag is set. Other pin activity leaves `cap_val` unchanged.
- R4: In mode 01, edge/level 01, 10 and 11 toggle, clear and set the output level respectively in the cycle after the counter equals the compare value. Edge/level 00 leaves the level alone and keeps `pin_en` low. `pin_en` is high in every output mode whose edge/level is nonzero.
- R5: With `tov_en` high in an active output mode, each overflow strobe sets the level to 1 in clear-on-compare and inverts it in the other actions.
- R6: When the overflow strobe and a compare match fall in the same cycle with `tov_en` high, the overflow action is applied and the compare action is dropped.
- R7: `max_duty` is sampled at each overflow strobe. While the sampled value is 1, `tov_en` is high and clear-on-compare is selected, compare matches do not clear the level, so the pin stays high for whole periods.
- R8: In mode 1X (buffered), a compare write (`wr_sel`=1) goes to a shadow register. The shadow is copied into the active compare value at the overflow strobe. In mode 0X the write goes to the active value directly.
- R9: A compare match in any output mode (mode 01, or mode 1X with nonzero edge/level) sets `evt_flag`. The flag is cleared only by a write with `wr_sel`=2 and `wr_data[0]`=1. A new event in the same cycle wins over the clear, and writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | One-cycle strobe in the cycle the counter wraps |
| cap_pin | input | 1 | Capture input pin |
| wr_valid | input | 1 | Register write strobe, accepted every cycle |
| wr_sel | input | 2 | Write target: 0 control, 1 compare, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| tov_en | input | 1 | Act on the output at each overflow |
| max_duty | input | 1 | Request full-high PWM periods |
| pin_out | output | 1 | Timer output level |
| pin_en | output | 1 | Timer owns the pin |
| cap_val | output | CNT_W | Captured counter value |
| evt_flag | output | 1 | Sticky channel event flag |

## Verification
The bench builds the channel with CNT_W=8 and drives its own counter that wraps every 20 cycles. Overflows therefore come often enough for dozens of PWM periods in a short run. With the small width, a compare value equal to the wrap point is easy to reach, so a match and an overflow fall in the same cycle (R6). It also lets a buffered compare write land in the middle of a period and be observed not to take effect until the next wrap.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  typedef struct packed {
    logic [1:0] ms;
    logic [1:0] els;
  } chan_mode_t;

  function automatic logic is_capture(chan_mode_t m);
    return (m.ms == 2'b00) && (m.els != 2'b00);
  endfunction

  function automatic logic is_out_mode(chan_mode_t m);
    return (m.ms == 2'b01) || (m.ms[1] && (m.els != 2'b00));
  endfunction

  function automatic logic drives_pin(chan_mode_t m);
    return is_out_mode(m) && (m.els != 2'b00);
  endfunction

endpackage

// File: rtl/timer_chan_regs.sv
module timer_chan_regs
  import timer_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit BUF_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_ovf,
  output chan_mode_t       mode,
  output logic             ctrl_wr,
  output logic             buffered,
  output logic [CNT_W-1:0] cmp_active
);

  logic cmp_wr;

  assign ctrl_wr = wr_valid && (wr_sel == SEL_CTRL);
  assign cmp_wr  = wr_valid && (wr_sel == SEL_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (ctrl_wr) begin
      mode.ms  <= wr_data[3:2];
      mode.els <= wr_data[1:0];
    end
  end

  generate
    if (BUF_EN) begin : g_shadow
      logic [CNT_W-1:0] cmp_shadow;
      assign buffered = mode.ms[1];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp_shadow <= '0;
        end else if (cmp_wr && buffered) begin
          cmp_shadow <= wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp_active <= '0;
        end else if (cmp_wr && !buffered) begin
          cmp_active <= wr_data;
        end else if (buffered && cnt_ovf) begin
          cmp_active <= cmp_shadow;
        end
      end
    end else begin : g_direct
      assign buffered = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp_active <= '0;
        end else if (cmp_wr) begin
          cmp_active <= wr_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/timer_chan_capture.sv
module timer_chan_capture
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_mode_t       mode,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             cap_hit,
  output logic [CNT_W-1:0] cap_val
);

  logic pin_q;
  logic rise;
  logic fall;

  assign rise    = cap_pin && !pin_q;
  assign fall    = !cap_pin && pin_q;
  assign cap_hit = is_capture(mode) &&
                   ((mode.els[0] && rise) || (mode.els[1] && fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      cap_val <= '0;
    end else begin
      pin_q <= cap_pin;
      if (cap_hit) begin
        cap_val <= cnt_val;
      end
    end
  end

endmodule

// File: rtl/timer_chan_drive.sv
module timer_chan_drive
  import timer_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_t mode,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_data,
  input  logic       cnt_ovf,
  input  logic       match,
  input  logic       tov_en,
  input  logic       max_duty,
  output logic       level
);

  logic max_eff;
  logic clr_sel;
  logic hold_high;
  act_e act;

  assign act       = act_e'(mode.els);
  assign clr_sel   = (act == ACT_CLR);
  assign hold_high = tov_en && max_eff && clr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_eff <= 1'b0;
    end else if (cnt_ovf) begin
      max_eff <= max_duty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
    end else if (ctrl_wr && (ctrl_data[1:0] == 2'b00)) begin
      level <= !ctrl_data[2];
    end else if (drives_pin(mode)) begin
      if (tov_en && cnt_ovf) begin
        level <= clr_sel ? 1'b1 : !level;
      end else if (match) begin
        unique case (act)
          ACT_TOG: level <= !level;
          ACT_CLR: level <= hold_high;
          ACT_SET: level <= 1'b1;
          default: level <= level;
        endcase
      end
    end
  end

endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit BUF_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_ovf,
  input  logic             cap_pin,
  input  logic             wr_valid,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tov_en,
  input  logic             max_duty,
  output logic             pin_out,
  output logic             pin_en,
  output logic [CNT_W-1:0] cap_val,
  output logic             evt_flag
);

  chan_mode_t       mode;
  logic [1:0]       mode_ms;
  logic [1:0]       mode_els;
  logic             ctrl_wr;
  logic             buffered;
  logic [CNT_W-1:0] cmp_active;
  logic             cap_hit;
  logic             match;
  logic             flag_set;
  logic             flag_clr;

  timer_chan_regs #(.CNT_W(CNT_W), .BUF_EN(BUF_EN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cnt_ovf    (cnt_ovf),
    .mode       (mode),
    .ctrl_wr    (ctrl_wr),
    .buffered   (buffered),
    .cmp_active (cmp_active)
  );

  timer_chan_capture #(.CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .cap_pin (cap_pin),
    .cnt_val (cnt_val),
    .cap_hit (cap_hit),
    .cap_val (cap_val)
  );

  assign match = (cnt_val == cmp_active);

  timer_chan_drive u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ctrl_wr   (ctrl_wr),
    .ctrl_data (wr_data[3:0]),
    .cnt_ovf   (cnt_ovf),
    .match     (match),
    .tov_en    (tov_en),
    .max_duty  (max_duty),
    .level     (pin_out)
  );

  assign mode_ms  = mode.ms;
  assign mode_els = mode.els;
  assign pin_en   = drives_pin(mode);
  assign flag_set = (is_out_mode(mode) && match) || cap_hit;
  assign flag_clr = wr_valid && (wr_sel == SEL_FLAG) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_flag <= 1'b0;
    end else if (flag_set) begin
      evt_flag <= 1'b1;
    end else if (flag_clr) begin
      evt_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_ovf,
  input logic             tov_en,
  input logic             wr_valid,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             pin_out,
  input logic             pin_en,
  input logic             evt_flag,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_hit,
  input logic             buffered,
  input logic [CNT_W-1:0] cmp_active,
  input logic [1:0]       mode_els
);

  assert_preset_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd0 && wr_data[1:0] == 2'b00)
    |=> (!pin_en && (pin_out == !$past(wr_data[2]))));

  assert_cap_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (cap_val == $past(cnt_val)) && evt_flag);

  assert_ovf_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tov_en && cnt_ovf && pin_en && mode_els == 2'b10 &&
     !(wr_valid && wr_sel == 2'd0))
    |=> pin_out);

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !cnt_ovf) |=> $stable(cmp_active));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !(wr_valid && wr_sel == 2'd2 && wr_data[0])) |=> evt_flag);

endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_val    (cnt_val),
  .cnt_ovf    (cnt_ovf),
  .tov_en     (tov_en),
  .wr_valid   (wr_valid),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .pin_out    (pin_out),
  .pin_en     (pin_en),
  .evt_flag   (evt_flag),
  .cap_val    (cap_val),
  .cap_hit    (cap_hit),
  .buffered   (buffered),
  .cmp_active (cmp_active),
  .mode_els   (mode_els)
);

// File: tb/timer_chan_tb.sv
module timer_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int MOD = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val;
  logic         cnt_ovf;
  logic         cap_pin = 1'b0;
  logic         wr_valid = 1'b0;
  logic [1:0]   wr_sel = 2'd3;
  logic [W-1:0] wr_data = '0;
  logic         tov_en = 1'b0;
  logic         max_duty = 1'b0;
  logic         pin_out, pin_en, evt_flag;
  logic [W-1:0] cap_val;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_val <= '0;
    else        cnt_val <= (cnt_val == MOD) ? '0 : cnt_val + 1'b1;
  assign cnt_ovf = (cnt_val == MOD);

  timer_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .cap_pin(cap_pin), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .tov_en(tov_en), .max_duty(max_duty), .pin_out(pin_out), .pin_en(pin_en),
    .cap_val(cap_val), .evt_flag(evt_flag)
  );

  // Behavioural reference, built from the requirement text.
  int m_ms = 0, m_els = 0, m_cmp = 0, m_shadow = 0, m_cap = 0;
  int m_lvl = 0, m_flag = 0, m_max = 0, m_prev = 0;

  function automatic int drives(int ms, int els);
    return ((ms == 1) || (ms >= 2)) && (els != 0);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int n_ms, n_els, n_cmp, n_shadow, n_cap, n_lvl, n_flag, n_max;
      int pin, hit, match, outm, evt;
      n_ms = m_ms; n_els = m_els; n_cmp = m_cmp; n_shadow = m_shadow;
      n_cap = m_cap; n_lvl = m_lvl; n_flag = m_flag; n_max = m_max;
      pin = int'(cap_pin);
      match = (int'(cnt_val) == m_cmp);
      outm = (m_ms == 1) || (m_ms >= 2 && m_els != 0);
      hit = 0;
      if (m_ms == 0 && m_els != 0) begin
        if ((m_els == 1 || m_els == 3) && pin == 1 && m_prev == 0) hit = 1;
        if ((m_els == 2 || m_els == 3) && pin == 0 && m_prev == 1) hit = 1;
      end
      if (hit) n_cap = int'(cnt_val);
      if (cnt_ovf) n_max = int'(max_duty);
      if (wr_valid && wr_sel == 1) begin
        if (m_ms >= 2) n_shadow = int'(wr_data);
        else           n_cmp = int'(wr_data);
      end
      if (m_ms >= 2 && cnt_ovf) n_cmp = m_shadow;
      if (wr_valid && wr_sel == 0 && wr_data[1:0] == 0) begin
        n_lvl = wr_data[2] ? 0 : 1;
      end else if (drives(m_ms, m_els)) begin
        if (tov_en && cnt_ovf) n_lvl = (m_els == 2) ? 1 : 1 - m_lvl;
        else if (match) begin
          if (m_els == 1) n_lvl = 1 - m_lvl;
          else if (m_els == 2) n_lvl = (tov_en && m_max) ? 1 : 0;
          else n_lvl = 1;
        end
      end
      if (wr_valid && wr_sel == 0) begin
        n_ms = int'(wr_data[3:2]); n_els = int'(wr_data[1:0]);
      end
      evt = (outm && match) || hit;
      if (evt) n_flag = 1;
      else if (wr_valid && wr_sel == 2 && wr_data[0]) n_flag = 0;
      m_ms = n_ms; m_els = n_els; m_cmp = n_cmp; m_shadow = n_shadow;
      m_cap = n_cap; m_lvl = n_lvl; m_flag = n_flag; m_max = n_max;
      m_prev = pin;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(pin_out) == m_lvl, cur_req, "pin_out", int'(pin_out), m_lvl);
      check(int'(pin_en) == drives(m_ms, m_els), cur_req, "pin_en",
            int'(pin_en), drives(m_ms, m_els));
      check(int'(cap_val) == m_cap, cur_req, "cap_val", int'(cap_val), m_cap);
      check(int'(evt_flag) == m_flag, cur_req, "evt_flag", int'(evt_flag), m_flag);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = W'(data);
    @(negedge clk);
    wr_valid = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic wait_cnt(input int v);
    @(negedge clk);
    while (int'(cnt_val) != v) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset state
    check(pin_out == 1'b0 && pin_en == 1'b0, "R1", "pins", int'(pin_out), 0);
    check(cap_val == '0 && evt_flag == 1'b0, "R1", "cap/flag", int'(cap_val), 0);
    rst_n = 1'b1;
    tick(2);

    // R2: preset levels
    cur_req = "R2";
    wr(2'd0, 8'h8); tick(1);
    check(pin_out == 1'b1 && !pin_en, "R2", "preset high", int'(pin_out), 1);
    wr(2'd0, 8'h4); tick(1);
    check(pin_out == 1'b0 && !pin_en, "R2", "preset low", int'(pin_out), 0);

    // R3: capture edges
    cur_req = "R3";
    for (int e = 1; e <= 3; e++) begin
      wr(2'd0, e);
      for (int k = 0; k < 4; k++) begin
        tick(3 + k); cap_pin = ~cap_pin;
      end
      tick(3);
      wr(2'd2, 1);
    end
    cap_pin = 1'b0;
    wr(2'd0, 8'h1); tick(2); cap_pin = 1'b1; tick(2);
    check(int'(cap_val) == m_cap && evt_flag, "R3", "rise capture", int'(cap_val), m_cap);
    cap_pin = 1'b0;

    // R4: unbuffered compare actions, no overflow action
    cur_req = "R4";
    wr(2'd1, 7);
    for (int e = 0; e <= 3; e++) begin
      wr(2'd0, 8'h4 | e);
      tick(45);
      wr(2'd2, 1);
    end

    // R9: writing 0 to flag has no effect; writing 1 clears
    cur_req = "R9";
    wr(2'd0, 8'h5); wait_cnt(9);
    wr(2'd2, 0); tick(1);
    check(evt_flag == 1'b1, "R9", "flag kept", int'(evt_flag), 1);
    wr(2'd2, 1); tick(1);
    check(evt_flag == 1'b0, "R9", "flag cleared", int'(evt_flag), 0);

    // R5: PWM with overflow action
    cur_req = "R5";
    tov_en = 1'b1;
    wr(2'd1, 5); wr(2'd0, 8'h6);
    tick(60);
    wr(2'd0, 8'h5); tick(60);

    // R6: overflow and compare in the same cycle
    cur_req = "R6";
    wr(2'd1, MOD); wr(2'd0, 8'h6);
    wait_cnt(0); tick(1);
    check(pin_out == 1'b1, "R6", "overflow beats clear", int'(pin_out), 1);
    tick(40);
    wr(2'd0, 8'h7); tick(40);

    // R7: max duty latency
    cur_req = "R7";
    wr(2'd1, 8); wr(2'd0, 8'h6);
    wait_cnt(3); max_duty = 1'b1;
    wait_cnt(10);
    check(pin_out == 1'b0, "R7", "same period still clears", int'(pin_out), 0);
    wait_cnt(10);
    check(pin_out == 1'b1, "R7", "full-high period", int'(pin_out), 1);
    wait_cnt(3); max_duty = 1'b0;
    wait_cnt(10);
    check(pin_out == 1'b1, "R7", "held until next period", int'(pin_out), 1);
    wait_cnt(10);
    check(pin_out == 1'b0, "R7", "clears again", int'(pin_out), 0);

    // R8: buffered compare
    cur_req = "R8";
    wr(2'd0, 8'hA);
    wr(2'd1, 4); tick(45);
    wait_cnt(2); wr(2'd1, 12);
    wait_cnt(8);
    check(pin_out == 1'b0, "R8", "old compare in period", int'(pin_out), 0);
    wait_cnt(8);
    check(pin_out == 1'b1, "R8", "new compare not yet", int'(pin_out), 1);
    wait_cnt(14);
    check(pin_out == 1'b0, "R8", "new compare applied", int'(pin_out), 0);
    tick(30);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule